// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor on two request lines and one wake line. Each source has a three-bit trigger mode. The mode selects no trigger, one edge polarity, both edges, or a level polarity. Edges are captured in separate rising and falling latches. Level sources stay pending for as long as the input holds the active level.

Software reaches every control register over a plain 32-bit register bus. Each control register has two addresses. At the lower address, writing 1s sets bits and a read returns the register. At the address 4 bytes above, writing 1s clears bits. A per-source steering bit chooses which request line a source feeds, so that urgent sources can be given a line of their own. A per-source mask gates the request lines. A separate per-source wake enable feeds the wake line without regard to the mask.

Top module: `dual_req_intc`

## Requirements
- R1: After reset, the trigger planes, assign, wake and mask registers read 0. The source register reads all ones. Both edge latches and the test register read 0. `irq_req0`, `irq_req1` and `wake_o` are low.
- R2: There are seven control registers. The set address of register i is 0x40+8*i and its clear address is 0x44+8*i. Registers 0 to 6 are trigger planes 0, 1 and 2, source, assign, wake and mask. Writing 1s at the set address ORs them into the register. Writing 1s at the clear address removes them. Reading the set address returns the register.
- R3: The trigger mode of source k is {plane2[k], plane1[k], plane0[k]}. A rising-edge latch bit is set only in modes 001 and 011, on a 0-to-1 change of the synchronized input. A falling-edge latch bit is set only in modes 010 and 011, on a 1-to-0 change. The latch is visible by the third clock edge after the input changes.
- R4: The rising latch reads at 0x78 and the falling latch at 0x7C. Writing 1s at either address clears those latch bits. An edge that is captured in the same cycle as the clear leaves the bit set.
- R5: Mode 101 makes a source pending while its synchronized input is high. Mode 110 makes it pending while the input is low. Modes 000, 100 and 111 never make a source pending.
- R6: A pending, unmasked source with assign bit 1 drives `irq_req0`. One with assign bit 0 drives `irq_req1`. Reads at 0x54 and 0x5C return those two per-source vectors.
- R7: A mask bit of 0 keeps its source off both request lines. It does not stop edge capture, and the held latch raises the request once the mask bit is set.
- R8: `wake_o` is the OR of the pending sources whose wake bit is 1, whatever their mask bits hold.
- R9: The test register at 0x80 is written and read as a whole word. The clear-only addresses 0x44, 0x4C, 0x64, 0x6C and 0x74, and all unmapped addresses, read 0.
- R10: In the edge modes a source is pending exactly while its rising or falling latch bit is set. Clearing the latch withdraws the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt source inputs |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data (one-hot or multi-bit masks) |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_req0 | output | 1 | Request line fed by assign bit 1 |
| irq_req1 | output | 1 | Request line fed by assign bit 0 |
| wake_o | output | 1 | Wake line from pending, wake-enabled sources |

## Verification
A corrupted trigger plane or a wrong mode decode shows up as an edge latch that sets or stays clear against its mode. It also shows up as a level source whose request bit at 0x54 follows the wrong input polarity. Both are visible by the third clock edge after the input moves. A faulty latch clear path is seen on the next read of 0x78 or 0x7C, and a lost set-wins ordering shows as a cleared bit right after the colliding write. Mis-steering or a broken mask gate appears at once on the request lines and on the two readback vectors.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int NPLANE     = 7;
   localparam int P_CFG0     = 0;
   localparam int P_CFG1     = 1;
   localparam int P_CFG2     = 2;
   localparam int P_SRC      = 3;
   localparam int P_ASSIGN   = 4;
   localparam int P_WAKE     = 5;
   localparam int P_MASK     = 6;

   localparam int OFS_BASE   = 'h40;
   localparam int OFS_STRIDE = 8;
   localparam int OFS_CLR    = 4;
   localparam int OFS_REQ0   = 'h54;
   localparam int OFS_REQ1   = 'h5C;
   localparam int OFS_RISE   = 'h78;
   localparam int OFS_FALL   = 'h7C;
   localparam int OFS_TEST   = 'h80;

   typedef enum logic [2:0] {
      TRIG_OFF  = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_FALL = 3'b010,
      TRIG_BOTH = 3'b011,
      TRIG_HIGH = 3'b101,
      TRIG_LOW  = 3'b110
   } trig_mode_e;

   function automatic logic mode_rise(input logic [2:0] m);
      return (m == TRIG_RISE) || (m == TRIG_BOTH);
   endfunction

   function automatic logic mode_fall(input logic [2:0] m);
      return (m == TRIG_FALL) || (m == TRIG_BOTH);
   endfunction

   function automatic logic mode_edge(input logic [2:0] m);
      return mode_rise(m) || mode_fall(m);
   endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("intc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q[s] <= '0;
            else if (s == 0)
               stage_q[s] <= d;
            else
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
   parameter int W        = 32,
   parameter bit RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (set_stb)
         q <= q | d;
      else if (clr_stb)
         q <= q & ~d;
   end

   // R2: bits written at the set address are present one cycle later
   a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((q & $past(d)) == $past(d)));
   // R2: bits written at the clear address are gone one cycle later
   a_r2_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((q & $past(d)) == '0));
endmodule

// File: rtl/intc_src_cell.sv
module intc_src_cell
   import intc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s_in,
   input  logic [2:0] mode,
   input  logic       clr_rise,
   input  logic       clr_fall,
   output logic       rise_lat,
   output logic       fall_lat,
   output logic       pending
);
   logic prev_q;
   logic rise_en, fall_en, rise_evt, fall_evt, level_hit;

   assign rise_en  = mode_rise(mode);
   assign fall_en  = mode_fall(mode);
   assign rise_evt = rise_en &  s_in & ~prev_q;
   assign fall_evt = fall_en & ~s_in &  prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         rise_lat <= 1'b0;
         fall_lat <= 1'b0;
      end else begin
         prev_q   <= s_in;
         rise_lat <= (rise_lat & ~clr_rise) | rise_evt;
         fall_lat <= (fall_lat & ~clr_fall) | fall_evt;
      end
   end

   always_comb begin
      unique case (mode)
         TRIG_HIGH: level_hit = s_in;
         TRIG_LOW:  level_hit = ~s_in;
         default:   level_hit = 1'b0;
      endcase
   end

   assign pending = mode_edge(mode) ? (rise_lat | fall_lat) : level_hit;

   // R3: no rising capture unless the mode includes the rising edge
   a_r3_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_en && !rise_lat) |=> !rise_lat);
   // R3: no falling capture unless the mode includes the falling edge
   a_r3_fall_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_en && !fall_lat) |=> !fall_lat);
   // R4: a clear with no colliding edge empties the latch
   a_r4_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rise && !rise_evt) |=> !rise_lat);
   // R4: a colliding edge wins over the clear
   a_r4_fall_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> fall_lat);
endmodule

// File: rtl/dual_req_intc.sv
module dual_req_intc
   import intc_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req0,
   output logic              irq_req1,
   output logic              wake_o
);
   localparam logic [ADDR_W-1:0] A_REQ0 = ADDR_W'(OFS_REQ0);
   localparam logic [ADDR_W-1:0] A_REQ1 = ADDR_W'(OFS_REQ1);
   localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE);
   localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL);
   localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(OFS_TEST);

   generate
      if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
         $error("dual_req_intc: NSRC must lie in 1..DATA_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("dual_req_intc: ADDR_W must reach offset 0x80");
      end
   endgenerate

   logic [NSRC-1:0]   wmask;
   logic [NSRC-1:0]   s_sync;
   logic [NSRC-1:0]   plane_q [NPLANE];
   logic [NSRC-1:0]   rise_q, fall_q, pend;
   logic [NSRC-1:0]   vec0, vec1;
   logic              clr_rise_stb, clr_fall_stb;
   logic [DATA_W-1:0] test_q;

   assign wmask = bus_wdata[NSRC-1:0];

   intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_in), .q(s_sync)
   );

   genvar g;
   generate
      for (g = 0; g < NPLANE; g++) begin : g_plane
         localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_BASE + OFS_STRIDE*g);
         localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_BASE + OFS_STRIDE*g + OFS_CLR);
         logic set_stb, clr_stb;
         assign set_stb = bus_we && (bus_addr == A_SET);
         assign clr_stb = bus_we && (bus_addr == A_CLR);
         intc_setclr_reg #(.W(NSRC), .RST_ONES(g == P_SRC)) u_reg (
            .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
            .d(wmask), .q(plane_q[g])
         );
      end
   endgenerate

   assign clr_rise_stb = bus_we && (bus_addr == A_RISE);
   assign clr_fall_stb = bus_we && (bus_addr == A_FALL);

   generate
      for (g = 0; g < NSRC; g++) begin : g_src
         intc_src_cell u_cell (
            .clk(clk), .rst_n(rst_n), .s_in(s_sync[g]),
            .mode({plane_q[P_CFG2][g], plane_q[P_CFG1][g], plane_q[P_CFG0][g]}),
            .clr_rise(clr_rise_stb & wmask[g]),
            .clr_fall(clr_fall_stb & wmask[g]),
            .rise_lat(rise_q[g]), .fall_lat(fall_q[g]), .pending(pend[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         test_q <= '0;
      else if (bus_we && bus_addr == A_TEST)
         test_q <= bus_wdata;
   end

   assign vec0     = pend & plane_q[P_MASK] &  plane_q[P_ASSIGN];
   assign vec1     = pend & plane_q[P_MASK] & ~plane_q[P_ASSIGN];
   assign irq_req0 = |vec0;
   assign irq_req1 = |vec1;
   assign wake_o   = |(pend & plane_q[P_WAKE]);

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NPLANE; i++) begin
         if (bus_addr == ADDR_W'(OFS_BASE + OFS_STRIDE*i))
            bus_rdata = DATA_W'(plane_q[i]);
      end
      unique case (bus_addr)
         A_REQ0:  bus_rdata = DATA_W'(vec0);
         A_REQ1:  bus_rdata = DATA_W'(vec1);
         A_RISE:  bus_rdata = DATA_W'(rise_q);
         A_FALL:  bus_rdata = DATA_W'(fall_q);
         A_TEST:  bus_rdata = test_q;
         default: ;
      endcase
   end

   // R7: a request line never rises while every mask bit is clear
   a_r7_req_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req0 || irq_req1) |-> (|plane_q[P_MASK]));
   // R8: the wake line needs at least one wake enable
   a_r8_wake_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (|plane_q[P_WAKE]));
   // R6: each request line needs a source steered to it
   a_r6_req0_steer: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req0 |-> (|plane_q[P_ASSIGN]));
   // R10: an edge-mode request is backed by a held latch bit
   a_r10_edge_backed: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req0 && (plane_q[P_CFG2] == '0)) |-> (|(rise_q | fall_q)));
endmodule

// File: tb/dual_req_intc_test.sv
module dual_req_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_req0, irq_req1, wake_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dual_req_intc uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_o(wake_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, b, pa, pb;
      int k;
      bit er, ef, ep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int i = 0; i < 7; i++) begin
         rd(8'(8'h40 + 8*i), v);
         chk("R1 plane reset", v, (i == 3) ? 32'hFFFF_FFFF : 32'h0);
      end
      rd(8'h78, v); chk("R1 rise latch reset", v, 0);
      rd(8'h7C, v); chk("R1 fall latch reset", v, 0);
      rd(8'h80, v); chk("R1 test reset", v, 0);
      chk("R1 outputs low", {29'd0, irq_req0, irq_req1, wake_o}, 0);

      // R2: set and clear on every plane
      for (int i = 0; i < 7; i++) begin
         pa = 32'hA5C3_0F96 ^ (32'h1111_1111 * i);
         pb = 32'h0FF0_33CC << i;
         wr(8'(8'h44 + 8*i), 32'hFFFF_FFFF);
         wr(8'(8'h40 + 8*i), pa);
         rd(8'(8'h40 + 8*i), v); chk("R2 set", v, pa);
         wr(8'(8'h44 + 8*i), pb);
         rd(8'(8'h40 + 8*i), v); chk("R2 clear", v, pa & ~pb);
         wr(8'(8'h44 + 8*i), 32'hFFFF_FFFF);
         rd(8'(8'h40 + 8*i), v); chk("R2 clear all", v, 0);
      end

      // R9: test register and addresses that read zero
      wr(8'h80, 32'hDEAD_BEEF);
      rd(8'h80, v); chk("R9 test reg", v, 32'hDEAD_BEEF);
      wr(8'h60, 32'h0000_F00F);
      rd(8'h64, v); chk("R9 clear address reads 0", v, 0);
      wr(8'h64, 32'hFFFF_FFFF);
      rd(8'h84, v); chk("R9 unmapped reads 0", v, 0);

      // R3 R5 R10: sweep all eight modes
      for (int m = 0; m < 8; m++) begin
         k = m * 4 + 1;
         b = 32'h1 << k;
         wr(m[0] ? 8'h40 : 8'h44, b);
         wr(m[1] ? 8'h48 : 8'h4C, b);
         wr(m[2] ? 8'h50 : 8'h54, b);
         wr(8'h70, b);
         wr(8'h60, b);
         er = (m == 1) || (m == 3);
         ef = (m == 2) || (m == 3);
         src_in[k] = 1'b1; settle();
         ep = (m inside {1, 2, 3}) ? er : (m == 5);
         rd(8'h78, v); chk("R3 rising latch", v, er ? b : 0);
         rd(8'h7C, v); chk("R3 no fall on rise", v, 0);
         rd(8'h54, v); chk("R5 pending after rise", v, ep ? b : 0);
         chk("R6 req0 line", {31'd0, irq_req0}, {31'd0, ep});
         src_in[k] = 1'b0; settle();
         ep = (m inside {1, 2, 3}) ? (er | ef) : (m == 6);
         rd(8'h7C, v); chk("R3 falling latch", v, ef ? b : 0);
         rd(8'h54, v); chk("R5 pending after fall", v, ep ? b : 0);
         wr(8'h78, b); wr(8'h7C, b);
         rd(8'h78, v); chk("R4 rise cleared", v, 0);
         rd(8'h7C, v); chk("R4 fall cleared", v, 0);
         rd(8'h54, v); chk("R10 pending follows latch", v, (m == 6) ? b : 0);
         wr(8'h44, b); wr(8'h4C, b); wr(8'h54, b); wr(8'h74, b); wr(8'h64, b);
      end

      // R6: steering between the two lines
      wr(8'h40, 32'hF); wr(8'h50, 32'hF);   // mode 101 on sources 0..3
      wr(8'h70, 32'hF); wr(8'h60, 32'h5);
      src_in[3:0] = 4'hF; settle();
      rd(8'h54, v); chk("R6 req0 vector", v, 32'h5);
      rd(8'h5C, v); chk("R6 req1 vector", v, 32'hA);
      chk("R6 both lines", {30'd0, irq_req0, irq_req1}, 32'h3);
      src_in[3:0] = 4'h5; settle();
      rd(8'h5C, v); chk("R6 req1 empty", v, 0);
      chk("R6 req1 line low", {31'd0, irq_req1}, 0);

      // R8: wake ignores the mask
      wr(8'h74, 32'hF); wr(8'h68, 32'h1);
      chk("R7 masked lines low", {30'd0, irq_req0, irq_req1}, 0);
      chk("R8 wake while masked", {31'd0, wake_o}, 1);
      wr(8'h6C, 32'h1);
      chk("R8 wake disabled", {31'd0, wake_o}, 0);
      src_in[3:0] = 4'h0;
      wr(8'h44, 32'hF); wr(8'h54, 32'hF); wr(8'h64, 32'hF);
      settle();

      // R7: masked edge is still latched, then raises the line
      b = 32'h1 << 20;
      wr(8'h40, b); wr(8'h60, b);
      src_in[20] = 1'b1; settle();
      rd(8'h78, v); chk("R7 latched while masked", v, b);
      chk("R7 req0 held off", {31'd0, irq_req0}, 0);
      wr(8'h70, b);
      chk("R7 req0 after unmask", {31'd0, irq_req0}, 1);

      // R4: edge colliding with a clear keeps the latch set
      src_in[20] = 1'b0; settle();
      src_in[20] = 1'b1;
      @(negedge clk); @(negedge clk);
      wr(8'h78, b);
      rd(8'h78, v); chk("R4 edge beats clear", v, b);
      wr(8'h78, b);
      rd(8'h78, v); chk("R4 later clear", v, 0);
      chk("R10 request withdrawn", {31'd0, irq_req0}, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule